// File: doc/BRIEF.md
# Programmable Setup-Command-Recovery Timing Generator

This block times each access made to a peripheral card bus. Every access runs through three phases in a fixed order. First the address is set up, then the active-low command strobe is asserted, and last the bus recovers. The length of each phase is a clock count. The counts come from one of two programmable timer sets. Every I/O window and every memory window owns one select bit, and that bit chooses which timer set its accesses use.

The host raises a request together with a window index. The block holds the host in wait from the moment it accepts the request until the final recovery clock, and then pulses done for one clock. A small register write port programs the two timer sets and the window select bits. The block also watches a power-good input. Whenever that input rises, both timer sets are restored to their defaults: a normal-wait set and a one-wait-state set.

Top module: `scr_timing_gen`

## Requirements
- R1: While and directly after reset, cmd_n is 1, host_wait is 0 and done is 0.
- R2: An accepted access holds host_wait high with cmd_n high for the setup count, then with cmd_n low for the command count, then with cmd_n high for the recovery count. All three counts are read from the timer set that the window selects.
- R3: A phase count of 0 produces exactly one clock in that phase. Counts are 6 bits wide, taken from wr_data[5:0].
- R4: Register map. Address 0, 1 and 2 hold the setup, command and recovery counts of set 0. Address 4, 5 and 6 hold the same counts of set 1. Address 8 holds the I/O window select bits, where bit i belongs to I/O window i. Address 9 holds the memory window select bits, where bit i belongs to memory window i. A select bit of 1 picks set 1. Window selects reset to 0.
- R5: After reset, set 0 is setup 1, command 3, recovery 2 (normal wait). Set 1 is setup 1, command 4, recovery 2 (one wait state).
- R6: host_wait goes high on the clock that follows acceptance and stays high through the last recovery clock. done is high for exactly one clock, the first clock after host_wait falls.
- R7: A timer-set write made during an access leaves that access unchanged and takes effect from the next accepted access.
- R8: A request raised while host_wait is high is ignored, and no further access follows once the current one ends.
- R9: A rising edge on power-good reloads both timer sets with the R5 defaults within 5 clocks. A power-good level that stays high reloads nothing, and the window select bits are kept.
- R10: A write to an address outside the R4 map changes no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pgood | input | 1 | Asynchronous power-good level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| req | input | 1 | Access request, accepted while host_wait is low |
| req_is_mem | input | 1 | 1 selects a memory window, 0 an I/O window |
| req_win | input | WIN_W | Window index |
| cmd_n | output | 1 | Active-low command strobe |
| host_wait | output | 1 | Host wait, held through the access |
| done | output | 1 | One-clock pulse when the access completes |

## Verification
A fault in the phase counter or in the latched timing shows up as a phase whose length in clocks is wrong. This is visible on cmd_n and host_wait within the access where the fault occurs. A wrong select bit or a wrong set register shows up as a whole access timed by the other set. A missed or spurious power-good reload appears in the first access after the edge. A sequencer that restarts, or that accepts a request while busy, leaves host_wait high past the done pulse or makes done come back.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

    localparam int CNT_W = 6;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] command;
        logic [CNT_W-1:0] recovery;
    } tset_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_CMD   = 2'd2,
        PH_RECOV = 2'd3
    } phase_e;

    localparam logic [CNT_W-1:0] DEF_SETUP    = CNT_W'(1);
    localparam logic [CNT_W-1:0] DEF_CMD_NORM = CNT_W'(3);
    localparam logic [CNT_W-1:0] DEF_RECOV    = CNT_W'(2);

    // register field selectors in the low two address bits
    localparam logic [1:0] FLD_SETUP = 2'd0;
    localparam logic [1:0] FLD_CMD   = 2'd1;
    localparam logic [1:0] FLD_RECOV = 2'd2;

    localparam int IO_SEL_ADDR  = 8;
    localparam int MEM_SEL_ADDR = 9;

    function automatic tset_t default_set(input logic one_wait);
        tset_t t;
        t.setup    = DEF_SETUP;
        t.command  = DEF_CMD_NORM + CNT_W'(one_wait);
        t.recovery = DEF_RECOV;
        return t;
    endfunction

    // phase length in clocks: a zero count still gives one clock
    function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] c);
        return (c == '0) ? CNT_W'(1) : c;
    endfunction

endpackage

// File: rtl/scr_pgood_detect.sv
`timescale 1ns/1ps
module scr_pgood_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pgood_in,
    output logic load_defaults
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   edge_w;
    logic                   load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            load_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pgood_in};
            prev_q <= sync_q[SYNC_STAGES-1];
            load_q <= edge_w;
        end
    end

    assign edge_w        = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign load_defaults = load_q;
endmodule

// File: rtl/scr_timer_bank.sv
`timescale 1ns/1ps
module scr_timer_bank
    import scr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_defaults,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output tset_t [1:0]       sets_o
);
    localparam int N_SETS = 2;

    tset_t [N_SETS-1:0] sets_q;

    for (genvar g = 0; g < N_SETS; g++) begin : g_set
        logic hit;
        assign hit = wr_en && (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(g));

        always_ff @(posedge clk) begin
            if (rst || load_defaults) begin
                sets_q[g] <= default_set(1'(g));
            end else if (hit) begin
                case (wr_addr[1:0])
                    FLD_SETUP: sets_q[g].setup    <= wr_data[CNT_W-1:0];
                    FLD_CMD:   sets_q[g].command  <= wr_data[CNT_W-1:0];
                    FLD_RECOV: sets_q[g].recovery <= wr_data[CNT_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    assign sets_o = sets_q;
endmodule

// File: rtl/scr_window_map.sv
`timescale 1ns/1ps
module scr_window_map #(
    parameter int N_IO_WIN  = 2,
    parameter int N_MEM_WIN = 5,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int WIN_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              is_mem,
    input  logic [WIN_W-1:0]  win,
    output logic              use_set1
);
    localparam int SLOTS = 1 << WIN_W;

    logic [N_IO_WIN-1:0]  io_sel_q;
    logic [N_MEM_WIN-1:0] mem_sel_q;
    logic [SLOTS-1:0]     io_pad;
    logic [SLOTS-1:0]     mem_pad;

    always_ff @(posedge clk) begin
        if (rst) begin
            io_sel_q  <= '0;
            mem_sel_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(scr_pkg::IO_SEL_ADDR))
                io_sel_q <= wr_data[N_IO_WIN-1:0];
            if (wr_addr == ADDR_W'(scr_pkg::MEM_SEL_ADDR))
                mem_sel_q <= wr_data[N_MEM_WIN-1:0];
        end
    end

    // windows beyond the implemented count read as set 0
    assign io_pad   = SLOTS'(io_sel_q);
    assign mem_pad  = SLOTS'(mem_sel_q);
    assign use_set1 = is_mem ? mem_pad[win] : io_pad[win];
endmodule

// File: rtl/scr_phase_seq.sv
`timescale 1ns/1ps
module scr_phase_seq
    import scr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  tset_t timing,
    output logic  cmd_n,
    output logic  host_wait,
    output logic  done
);
    phase_e           state_q;
    logic [CNT_W-1:0] cnt_q;
    tset_t            lat_q;
    logic             done_q;
    logic             last_clk;

    assign last_clk = (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            lat_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                PH_IDLE: begin
                    if (req) begin
                        lat_q   <= timing;
                        cnt_q   <= eff_len(timing.setup);
                        state_q <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (last_clk) begin
                        cnt_q   <= eff_len(lat_q.command);
                        state_q <= PH_CMD;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_CMD: begin
                    if (last_clk) begin
                        cnt_q   <= eff_len(lat_q.recovery);
                        state_q <= PH_RECOV;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (last_clk) begin
                        state_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    assign cmd_n     = (state_q != PH_CMD);
    assign host_wait = (state_q != PH_IDLE);
    assign done      = done_q;
endmodule

// File: rtl/scr_timing_gen.sv
`timescale 1ns/1ps
module scr_timing_gen
    import scr_pkg::*;
#(
    parameter int N_IO_WIN  = 2,
    parameter int N_MEM_WIN = 5,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    localparam int MAX_WIN  = (N_IO_WIN > N_MEM_WIN) ? N_IO_WIN : N_MEM_WIN,
    localparam int WIN_W    = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgood,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req,
    input  logic              req_is_mem,
    input  logic [WIN_W-1:0]  req_win,
    output logic              cmd_n,
    output logic              host_wait,
    output logic              done
);
    logic        load_defaults;
    tset_t [1:0] sets;
    logic        use_set1;
    tset_t       chosen;

    scr_pgood_detect #(.SYNC_STAGES(2)) u_pgood (
        .clk           (clk),
        .rst           (rst),
        .pgood_in      (pgood),
        .load_defaults (load_defaults)
    );

    scr_timer_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk           (clk),
        .rst           (rst),
        .load_defaults (load_defaults),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .sets_o        (sets)
    );

    scr_window_map #(
        .N_IO_WIN  (N_IO_WIN),
        .N_MEM_WIN (N_MEM_WIN),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .WIN_W     (WIN_W)
    ) u_map (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .is_mem   (req_is_mem),
        .win      (req_win),
        .use_set1 (use_set1)
    );

    assign chosen = use_set1 ? sets[1] : sets[0];

    scr_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .timing    (chosen),
        .cmd_n     (cmd_n),
        .host_wait (host_wait),
        .done      (done)
    );
endmodule

// File: rtl/scr_timing_chk.sv
`timescale 1ns/1ps
module scr_timing_chk (
    input logic clk,
    input logic rst,
    input logic req,
    input logic cmd_n,
    input logic host_wait,
    input logic done
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (cmd_n && !host_wait && !done));

    // R2
    strobe_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_n |-> host_wait);

    // R2
    recovery_follows_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_n) |-> host_wait);

    // R6
    accept_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !host_wait) |=> host_wait);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !host_wait);

    // R6
    release_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(host_wait) |-> done);
endmodule

bind scr_timing_gen scr_timing_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .cmd_n     (cmd_n),
    .host_wait (host_wait),
    .done      (done)
);

// File: tb/tb_scr_timing_gen.sv
`timescale 1ns/1ps
module tb_scr_timing_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pgood = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       req = 1'b0;
    logic       req_is_mem = 1'b0;
    logic [2:0] req_win = '0;
    logic       cmd_n;
    logic       host_wait;
    logic       done;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    scr_timing_gen dut (
        .clk        (clk),
        .rst        (rst),
        .pgood      (pgood),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .req        (req),
        .req_is_mem (req_is_mem),
        .req_win    (req_win),
        .cmd_n      (cmd_n),
        .host_wait  (host_wait),
        .done       (done)
    );

    function automatic int eff(input int c);
        return (c == 0) ? 1 : c;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_reg(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // runs one access, measures phase lengths, checks the done pulse (R6)
    task automatic run_access(input logic m, input int w, input int mid_addr,
                              input int mid_data, input bit busy,
                              output int s, output int c, output int r);
        int seen_done;
        s = 0; c = 0; r = 0; seen_done = 0;
        @(negedge clk);
        req_is_mem = m; req_win = 3'(w); req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (i == 1 && mid_addr >= 0) begin
                wr_en = 1'b1; wr_addr = 4'(mid_addr); wr_data = 8'(mid_data);
            end else begin
                wr_en = 1'b0;
            end
            req = (busy && i == 2);
            if (host_wait) begin
                if (!cmd_n) c++;
                else if (c == 0) s++;
                else r++;
            end else begin
                seen_done = int'(done);
                break;
            end
            @(negedge clk);
        end
        wr_en = 1'b0; req = 1'b0;
        chk("R6 done on first idle clock", seen_done, 1);
        @(negedge clk);
        chk("R6 done lasts one clock", int'(done), 0);
        chk("R8 no access after done", int'(host_wait), 0);
    endtask

    task automatic expect_access(input string tag, input logic m, input int w,
                                 input int es, input int ec, input int er);
        int s, c, r;
        run_access(m, w, -1, 0, 1'b0, s, c, r);
        chk({tag, " setup"}, s, es);
        chk({tag, " command"}, c, ec);
        chk({tag, " recovery"}, r, er);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cmd_n in reset", int'(cmd_n), 1);
        chk("R1 host_wait in reset", int'(host_wait), 0);
        chk("R1 done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cmd_n after reset", int'(cmd_n), 1);
        chk("R1 host_wait after reset", int'(host_wait), 0);
    endtask

    task automatic t_defaults();
        expect_access("R5 set0 default io0", 1'b0, 0, 1, 3, 2);
        expect_access("R5 set0 default mem4", 1'b1, 4, 1, 3, 2);
        write_reg(8, 8'b10);
        expect_access("R4 io1 on set1 default", 1'b0, 1, 1, 4, 2);
        expect_access("R4 io0 stays set0", 1'b0, 0, 1, 3, 2);
    endtask

    task automatic t_program();
        write_reg(0, 5); write_reg(1, 7); write_reg(2, 3);
        expect_access("R2 programmed set0", 1'b0, 0, 5, 7, 3);
        write_reg(4, 2); write_reg(5, 6); write_reg(6, 4);
        write_reg(9, 8'b01000);
        expect_access("R4 mem3 on set1", 1'b1, 3, 2, 6, 4);
        expect_access("R4 mem2 on set0", 1'b1, 2, 5, 7, 3);
    endtask

    task automatic t_zero();
        write_reg(4, 0); write_reg(5, 0); write_reg(6, 0);
        expect_access("R3 zero counts", 1'b1, 3, 1, 1, 1);
        write_reg(5, 63);
        expect_access("R3 full command count", 1'b1, 3, 1, 63, 1);
    endtask

    task automatic t_mid_write();
        int s, c, r;
        run_access(1'b0, 0, 1, 10, 1'b0, s, c, r);
        chk("R7 current command unchanged", c, 7);
        chk("R7 current setup unchanged", s, 5);
        expect_access("R7 next access uses write", 1'b0, 0, 5, 10, 3);
    endtask

    task automatic t_busy();
        int s, c, r;
        run_access(1'b0, 0, -1, 0, 1'b1, s, c, r);
        chk("R8 busy request setup", s, 5);
        chk("R8 busy request command", c, 10);
        chk("R8 busy request recovery", r, 3);
    endtask

    task automatic t_bad_addr();
        write_reg(3, 9); write_reg(7, 9); write_reg(12, 9); write_reg(15, 9);
        expect_access("R10 unmapped writes set0", 1'b0, 0, 5, 10, 3);
        expect_access("R10 unmapped writes set1", 1'b1, 3, 1, 63, 1);
    endtask

    task automatic t_pgood();
        @(negedge clk);
        pgood = 1'b1;
        repeat (5) @(negedge clk);
        expect_access("R9 set0 reloaded", 1'b0, 0, 1, 3, 2);
        expect_access("R9 selects kept, set1 reloaded", 1'b1, 3, 1, 4, 2);
        write_reg(0, 6);
        repeat (6) @(negedge clk);
        expect_access("R9 steady level no reload", 1'b0, 0, 6, 3, 2);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_defaults();
        t_program();
        t_zero();
        t_mid_write();
        t_busy();
        t_bad_addr();
        t_pgood();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule